// File: doc/BRIEF.md
# Byte-Paced Serial Stream Slave

This block is the device side of a serial data stream that an external controller drives. The controller always supplies the serial clock, in both directions. The device uses a request line to grant each byte. The controller may start a byte only while the request line is high. It looks at the line again after every byte to decide whether another byte may follow. There is no chip select and no fixed frame length: the request line alone paces the stream, one byte at a time.

A mode input from the core sets the direction. In controller-to-device mode the block samples the data line on rising serial clock edges, most significant bit first. It hands each completed byte to the core over a valid/ready handshake, and it holds the request line low while that one-byte buffer is full. In device-to-controller mode the core loads a byte over a second valid/ready handshake. The block raises the request line while that byte waits or is being shifted, and it moves to the next bit on each falling serial clock edge. The serial clock and data inputs are oversampled by the system clock through a synchronizer chain, and all edge detection runs in the system clock domain.

Top module: `stream_byte_slave`

## Requirements
- R1: After reset, rx_valid_o is 0, sdo_o is 0, tx_ready_o is 0 and, with mode_i at 0, req_o is 1.
- R2: With mode_i at 0 (controller to device), sdi_i is sampled on each rising sclk_i edge, most significant bit first. After the eighth rising edge the byte appears on rx_data_o with rx_valid_o at 1.
- R3: With mode_i at 0, req_o is 1 exactly while the receive buffer is empty. It goes low when a byte is presented, and it is high again in the cycle after rx_valid_o and rx_ready_i are both 1.
- R4: While rx_valid_o is 1 and rx_ready_i is 0, rx_valid_o stays 1 and rx_data_o does not change.
- R5: A byte that completes while the receive buffer is full is discarded, and the buffered byte is kept unchanged.
- R6: With mode_i at 1 (device to controller), tx_ready_o is 1 while no byte is loaded. A cycle with tx_valid_i and tx_ready_o both 1 loads tx_data_i. After that, req_o is 1 and tx_ready_o is 0 until the byte has been sent.
- R7: After a load, sdo_o shows the most significant bit at once and moves to the next bit after each falling sclk_i edge. After the eighth falling edge the byte is finished and req_o drops to 0.
- R8: Rising sclk_i edges in mode 1 leave the receive buffer untouched. tx_valid_i has no effect in mode 0: tx_ready_o stays 0 and nothing is loaded.
- R9: A change of mode_i clears the bit counter and drops any byte that was only partly sent. The next byte starts fresh in the new mode.
- R10: sdo_o is 0 in mode 0 and whenever no transmit byte is loaded.
- R11: With the default two synchronizer stages, rx_valid_o rises on the third system clock edge after the eighth rising edge of sclk_i, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: controller sends to device, 1: device sends to controller |
| sclk_i | input | 1 | Serial clock from the controller, idle low |
| sdi_i | input | 1 | Serial data from the controller |
| sdo_o | output | 1 | Serial data to the controller |
| req_o | output | 1 | Byte request line to the controller |
| rx_data_o | output | DATA_W | Received byte toward the core |
| rx_valid_o | output | 1 | Received byte is valid |
| rx_ready_i | input | 1 | Core accepts the received byte |
| tx_data_i | input | DATA_W | Byte from the core to send |
| tx_valid_i | input | 1 | Core offers a byte to send |
| tx_ready_o | output | 1 | Block can load a byte to send |

## Verification
A bit counter that is off by one shows on the ports within one byte. A received byte comes out rotated, or a sent byte reaches the controller shifted, and req_o changes one serial edge early or late. A buffer flag that is set or cleared wrongly shows at once as req_o in the wrong state, or as a byte lost or repeated on the core side. Every byte value is swept in both directions, so a stuck or swapped data bit shows as a wrong byte. Exact-cycle sampling around the final rising edge catches a synchronizer chain with a stage too many or too few.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;
endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stg_in;
    if (g == 0) begin : g_first
      assign stg_in = d_i;
    end else begin : g_next
      assign stg_in = stg[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[g] <= '0;
      else         stg[g] <= stg_in;
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sbs_edge.sv
module sbs_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/sbs_shifter.sv
module sbs_shifter
  import sbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dir_e              dir_i,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              rx_done_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              tx_busy_o,
  output logic              sdo_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-2:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;
  logic              tx_busy;
  logic              cnt_last;

  assign cnt_last = (cnt == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt     <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      tx_busy <= 1'b0;
    end else if (clr_i) begin
      // mode change: restart byte framing
      cnt     <= '0;
      tx_busy <= 1'b0;
    end else if (dir_i == DIR_RX) begin
      if (rise_i) begin
        rx_sr <= rx_word_o[DATA_W-2:0];
        cnt   <= cnt_last ? '0 : cnt + CNT_W'(1);
      end
    end else if (load_i) begin
      tx_sr   <= load_data_i;
      tx_busy <= 1'b1;
      cnt     <= '0;
    end else if (tx_busy && fall_i) begin
      tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      cnt   <= cnt_last ? '0 : cnt + CNT_W'(1);
      if (cnt_last) tx_busy <= 1'b0;
    end
  end

  assign rx_word_o = {rx_sr, sdi_i};
  assign rx_done_o = (dir_i == DIR_RX) && !clr_i && rise_i && cnt_last;
  assign tx_busy_o = tx_busy;
  assign sdo_o     = (dir_i == DIR_TX) && tx_busy && tx_sr[DATA_W-1];

  p_mode_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt == '0) && !tx_busy);

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i && dir_i == DIR_TX) |=> tx_busy && (tx_sr == $past(load_data_i)));

  p_tx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy && !fall_i && !clr_i && !load_i) |=> $stable(tx_sr) && tx_busy);
endmodule

// File: rtl/stream_byte_slave.sv
module stream_byte_slave
  import sbs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              req_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);
  dir_e              dir, dir_q;
  logic              clr;
  logic [1:0]        pins_s;
  logic              sclk_s, sdi_s;
  logic              rise, fall;
  logic              rx_done, tx_busy, load;
  logic [DATA_W-1:0] rx_word;
  logic [DATA_W-1:0] rx_buf;
  logic              rx_full;

  assign dir = dir_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= DIR_RX;
    else         dir_q <= dir;
  end
  assign clr = (dir != dir_q);

  sbs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdi_i}),
    .q_o   (pins_s)
  );
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  sbs_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sclk_s),
    .rise_o(rise),
    .fall_o(fall)
  );

  sbs_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dir_i      (dir),
    .clr_i      (clr),
    .rise_i     (rise),
    .fall_i     (fall),
    .sdi_i      (sdi_s),
    .load_i     (load),
    .load_data_i(tx_data_i),
    .rx_done_o  (rx_done),
    .rx_word_o  (rx_word),
    .tx_busy_o  (tx_busy),
    .sdo_o      (sdo_o)
  );

  // one-byte receive buffer; a byte arriving while full is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_full <= 1'b0;
      rx_buf  <= '0;
    end else if (rx_done && !rx_full) begin
      rx_full <= 1'b1;
      rx_buf  <= rx_word;
    end else if (rx_full && rx_ready_i) begin
      rx_full <= 1'b0;
    end
  end

  assign tx_ready_o = (dir == DIR_TX) && !clr && !tx_busy;
  assign load       = tx_valid_i && tx_ready_o;
  assign rx_valid_o = rx_full;
  assign rx_data_o  = rx_buf;
  assign req_o      = (dir == DIR_TX) ? tx_busy : !rx_full;

  p_valid_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> rx_valid_o && $stable(rx_data_o));

  p_req_back_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && rx_valid_o && rx_ready_i) |=> (mode_i || req_o));

  p_rx_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !rx_valid_o) |=> !rx_valid_o);
endmodule

// File: tb/tb_stream_byte_slave.sv
module tb_stream_byte_slave;
  localparam int HALF = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0;
  logic       sclk_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic       sdo_o;
  logic       req_o;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;
  logic       rx_ready_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  stream_byte_slave dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .sclk_i    (sclk_i),
    .sdi_i     (sdi_i),
    .sdo_o     (sdo_o),
    .req_o     (req_o),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o),
    .rx_ready_i(rx_ready_i),
    .tx_data_i (tx_data_i),
    .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic ctrl_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi_i = b[i];
      tick(HALF);
      sclk_i = 1'b1;
      tick(HALF);
      sclk_i = 1'b0;
    end
  endtask

  task automatic ctrl_recv(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      b[i] = sdo_o;
      sclk_i = 1'b1;
      tick(HALF);
      sclk_i = 1'b0;
    end
  endtask

  task automatic take_rx();
    rx_ready_i = 1'b1;
    tick(1);
    rx_ready_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    // R1 reset state
    chk(req_o == 1'b1 && rx_valid_o == 1'b0, "R1 req/valid", {req_o, rx_valid_o}, 2'b10);
    chk(sdo_o == 1'b0 && tx_ready_o == 1'b0, "R1 sdo/tx_ready", {sdo_o, tx_ready_o}, 0);

    // R2/R3/R4/R5 receive sweep
    for (int v = 0; v < 256; v++) begin
      chk(req_o == 1'b1, "R3 req before byte", req_o, 1);
      ctrl_bits(8'(v), 8);
      tick(HALF);
      chk(rx_valid_o && rx_data_o == 8'(v), "R2 rx byte", rx_data_o, v);
      chk(req_o == 1'b0, "R3 req low when full", req_o, 0);
      if (v % 16 == 5) begin
        ctrl_bits(~8'(v), 8);
        tick(HALF);
        chk(rx_valid_o && rx_data_o == 8'(v), "R5 overrun kept", rx_data_o, v);
        chk(rx_valid_o && rx_data_o == 8'(v), "R4 held", rx_data_o, v);
      end
      take_rx();
      chk(!rx_valid_o && req_o, "R3 req back after take", {rx_valid_o, req_o}, 2'b01);
    end

    // R11 latency of the final rising edge
    ctrl_bits(8'hA5, 7);
    sdi_i = 1'b1;
    tick(HALF);
    sclk_i = 1'b1;
    tick(2);
    chk(!rx_valid_o, "R11 not before third edge", rx_valid_o, 0);
    tick(1);
    chk(rx_valid_o && rx_data_o == 8'hA5, "R11 valid at third edge", rx_data_o, 8'hA5);
    tick(HALF);
    sclk_i = 1'b0;
    tick(HALF);
    take_rx();

    // R8 tx_valid ignored in mode 0
    tx_data_i = 8'h81;
    tx_valid_i = 1'b1;
    tick(3);
    chk(!tx_ready_o && !sdo_o && req_o, "R8 no load in rx mode", {tx_ready_o, sdo_o, req_o}, 3'b001);
    tx_valid_i = 1'b0;
    mode_i = 1'b1;
    tick(2);
    chk(!req_o && tx_ready_o && !sdo_o, "R8 nothing loaded", {req_o, tx_ready_o, sdo_o}, 3'b010);
    chk(!sdo_o, "R10 sdo idle", sdo_o, 0);

    // R6/R7/R10 transmit sweep
    for (int v = 0; v < 256; v++) begin
      tx_data_i = 8'(v);
      tx_valid_i = 1'b1;
      tick(1);
      tx_valid_i = 1'b0;
      chk(req_o && !tx_ready_o, "R6 loaded", {req_o, tx_ready_o}, 2'b10);
      chk(sdo_o == tx_data_i[7], "R7 msb at once", sdo_o, tx_data_i[7]);
      ctrl_recv(got);
      chk(got == 8'(v), "R7 tx byte", got, v);
      tick(HALF);
      chk(!req_o && tx_ready_o, "R7 req drops after byte", {req_o, tx_ready_o}, 2'b01);
      chk(!sdo_o, "R10 sdo idle after byte", sdo_o, 0);
    end
    chk(!rx_valid_o, "R8 rx buffer untouched in tx mode", rx_valid_o, 0);

    // R9 partial transmit dropped by mode change
    tx_data_i = 8'hFF;
    tx_valid_i = 1'b1;
    tick(1);
    tx_valid_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick(HALF);
      sclk_i = 1'b1;
      tick(HALF);
      sclk_i = 1'b0;
    end
    tick(HALF);
    mode_i = 1'b0;
    tick(2);
    chk(!sdo_o, "R10 sdo low in rx mode", sdo_o, 0);
    mode_i = 1'b1;
    tick(2);
    chk(!req_o && tx_ready_o, "R9 partial tx dropped", {req_o, tx_ready_o}, 2'b01);

    // R9 partial receive cleared by mode change
    mode_i = 1'b0;
    tick(2);
    ctrl_bits(8'hE0, 3);
    tick(HALF);
    mode_i = 1'b1;
    tick(2);
    mode_i = 1'b0;
    tick(2);
    chk(!rx_valid_o, "R9 no byte from partial", rx_valid_o, 0);
    ctrl_bits(8'h3C, 8);
    tick(HALF);
    chk(rx_valid_o && rx_data_o == 8'h3C, "R9 fresh byte after clear", rx_data_o, 8'h3C);
    take_rx();

    finish_run();
  end
endmodule